// File: doc/BRIEF.md
# LPC Target Cycle Responder

This block is the peripheral side of a Low Pin Count bus. It watches the 4-bit multiplexed LAD lines and the active-low frame strobe. It follows each host cycle through its start, type and address nibbles, and it answers only I/O or memory cycles whose address falls inside a configured window. On a hit it takes over the bus after the host's turnaround. It holds the host off with wait codes for as long as its register-side handshake needs. It then reports ready or error, returns read data when the cycle needs it, and gives the bus back through its own turnaround.

The register side sees one request per accepted cycle. The request carries a valid/ready pair together with the address, the direction, the address space and the write byte. Read data and an error flag are sampled in the cycle the handshake completes. The host can abandon a cycle at any point by pulling the frame strobe low. The responder then stops driving in that same cycle, withdraws its request and waits for the next start code. DMA, bus-master and firmware-hub cycle types are passed over without any response.

Top module: `lpc_target_resp`

## Requirements
- R1: After reset the block does not drive LAD and has no request pending. A cycle starts only in a clock where `frame_n` is 0 and `lad_i` is 4'b0000. While `frame_n` is high and no cycle is running, a 4'b0000 nibble has no effect.
- R2: The nibble after the start selects the cycle. When bit 3 is 0, bit 2 set means memory, bit 1 set means write, and bit 0 is ignored. When bit 3 is 1 (DMA, bus-master, firmware-hub or reserved), the block neither drives LAD nor raises a request.
- R3: The address follows as 4 nibbles for I/O and 8 nibbles for memory, most significant nibble first. `req_addr` carries the assembled value, zero-extended for I/O. `req_mem` and `req_write` carry the decoded type.
- R4: A cycle hits when `lo <= address <= hi`, with both bounds inclusive, using `io_lo`/`io_hi` for I/O and `mem_lo`/`mem_hi` for memory. On a miss the block never drives LAD and raises no request.
- R5: For a write, the data byte follows the address as two nibbles, bits 3:0 first and then bits 7:4. The request is raised with that byte on `req_wdata`.
- R6: During the host's two-clock turnaround after the last host nibble, the block does not drive LAD. The first nibble it drives is a SYNC code.
- R7: In each SYNC clock the block drives 4'b0110 (long wait) while its request is unfinished, with no limit on how many. In the clock after `req_valid && req_ready` it drives 4'b0000 (ready).
- R8: If `rsp_err` is 1 when the handshake completes, the SYNC code is 4'b1010. On a read, the two data nibbles are still driven after it.
- R9: On a read, the block drives the byte captured from `rsp_rdata` in the two clocks after SYNC, bits 3:0 first and then bits 7:4.
- R10: After the last SYNC or data nibble, the block drives 4'b1111 for one clock, releases LAD (`lad_oe`=0) the next clock, and is then idle.
- R11: In any clock where `frame_n` is 0, `lad_oe` is 0 in that same clock. Any request still pending is withdrawn at the next edge and the running cycle is dropped. If `lad_i` is 4'b0000 in that clock, it starts a new cycle.
- R12: Each accepted cycle raises exactly one request. `req_valid` stays high until a clock with `req_ready` high or an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_i | input | 4 | LAD nibble as seen on the bus |
| lad_o | output | 4 | Nibble the block drives onto LAD |
| lad_oe | output | 1 | Output enable for `lad_o` |
| io_lo | input | IO_AW | Lowest I/O address answered |
| io_hi | input | IO_AW | Highest I/O address answered |
| mem_lo | input | MEM_AW | Lowest memory address answered |
| mem_hi | input | MEM_AW | Highest memory address answered |
| req_valid | output | 1 | Register-side request pending |
| req_write | output | 1 | Request is a write |
| req_mem | output | 1 | Request targets memory space |
| req_addr | output | MEM_AW | Request address |
| req_wdata | output | 8 | Write byte |
| req_ready | input | 1 | Register side completes the request |
| rsp_rdata | input | 8 | Read byte, sampled at completion |
| rsp_err | input | 1 | Error flag, sampled at completion |

## Verification
Two functions can land in the same clock: the host's frame strobe, which aborts the cycle or starts a new one, and the responder's own bus drive during a long-wait SYNC. The bench holds the register side off for twenty clocks and drops the strobe after a few wait codes. In one run the strobe comes with a start nibble and is followed at once by a fresh write cycle. In another it comes with a non-start nibble. Just after driving the strobe low, the reference model checks that the output enable is already low in that same clock. In the next clocks it checks that the request is gone and that the restarted cycle completes with exactly one new request.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

    localparam int LPC_DW = 8;

    localparam logic [3:0] NIB_START  = 4'b0000;
    localparam logic [3:0] NIB_ONES   = 4'b1111;
    localparam logic [3:0] SYNC_READY = 4'b0000;
    localparam logic [3:0] SYNC_LWAIT = 4'b0110;
    localparam logic [3:0] SYNC_ERROR = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TYPE,
        ST_ADDR,
        ST_WDAT,
        ST_TAR_IN,
        ST_SYNC,
        ST_RDAT,
        ST_TAR_OUT
    } lpc_st_e;

endpackage

// File: rtl/lpc_win_match.sv
module lpc_win_match #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic          hit
);
    logic ge_lo;
    logic le_hi;

    always_comb begin
        ge_lo = (addr >= lo);
        le_hi = (addr <= hi);
        hit   = ge_lo && le_hi;
    end
endmodule

// File: rtl/lpc_req_port.sv
module lpc_req_port
    import lpc_tgt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              iss,
    input  logic              iss_write,
    input  logic              iss_mem,
    input  logic [AW-1:0]     iss_addr,
    input  logic [LPC_DW-1:0] iss_wdata,
    input  logic              req_ready,
    input  logic [LPC_DW-1:0] rsp_rdata,
    input  logic              rsp_err,
    output logic              req_valid,
    output logic              req_write,
    output logic              req_mem,
    output logic [AW-1:0]     req_addr,
    output logic [LPC_DW-1:0] req_wdata,
    output logic              done,
    output logic              err,
    output logic [LPC_DW-1:0] rdata
);
    typedef struct packed {
        logic              valid;
        logic              write;
        logic              mem;
        logic [AW-1:0]     addr;
        logic [LPC_DW-1:0] wdata;
        logic              done;
        logic              err;
        logic [LPC_DW-1:0] rdata;
    } port_t;

    port_t p_q, p_d;

    always_comb begin
        p_d = p_q;
        if (abort) begin
            p_d.valid = 1'b0;
            p_d.done  = 1'b0;
        end else if (iss) begin
            p_d.valid = 1'b1;
            p_d.write = iss_write;
            p_d.mem   = iss_mem;
            p_d.addr  = iss_addr;
            p_d.wdata = iss_wdata;
            p_d.done  = 1'b0;
            p_d.err   = 1'b0;
        end else if (p_q.valid && req_ready) begin
            p_d.valid = 1'b0;
            p_d.done  = 1'b1;
            p_d.err   = rsp_err;
            p_d.rdata = rsp_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign req_valid = p_q.valid;
    assign req_write = p_q.write;
    assign req_mem   = p_q.mem;
    assign req_addr  = p_q.addr;
    assign req_wdata = p_q.wdata;
    assign done      = p_q.done;
    assign err       = p_q.err;
    assign rdata     = p_q.rdata;
endmodule

// File: rtl/lpc_lad_drive.sv
module lpc_lad_drive
    import lpc_tgt_pkg::*;
(
    input  lpc_st_e           st,
    input  logic              second,
    input  logic              done,
    input  logic              err,
    input  logic [LPC_DW-1:0] rdata,
    input  logic              frame_n,
    output logic [3:0]        lad_o,
    output logic              lad_oe
);
    logic       drive;
    logic [3:0] nib;

    always_comb begin
        drive = 1'b0;
        nib   = 4'b0000;
        unique case (st)
            ST_SYNC: begin
                drive = 1'b1;
                if (!done) begin
                    nib = SYNC_LWAIT;
                end else if (err) begin
                    nib = SYNC_ERROR;
                end else begin
                    nib = SYNC_READY;
                end
            end
            ST_RDAT: begin
                drive = 1'b1;
                nib   = second ? rdata[7:4] : rdata[3:0];
            end
            ST_TAR_OUT: begin
                // first clock pulls high, second clock releases
                drive = !second;
                nib   = second ? 4'b0000 : NIB_ONES;
            end
            default: begin
                drive = 1'b0;
                nib   = 4'b0000;
            end
        endcase
    end

    // a low frame strobe takes the bus back in the same clock
    assign lad_oe = drive && frame_n;
    assign lad_o  = lad_oe ? nib : 4'b0000;
endmodule

// File: rtl/lpc_target_resp.sv
module lpc_target_resp
    import lpc_tgt_pkg::*;
#(
    parameter int IO_AW  = 16,
    parameter int MEM_AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [3:0]        lad_i,
    output logic [3:0]        lad_o,
    output logic              lad_oe,
    input  logic [IO_AW-1:0]  io_lo,
    input  logic [IO_AW-1:0]  io_hi,
    input  logic [MEM_AW-1:0] mem_lo,
    input  logic [MEM_AW-1:0] mem_hi,
    output logic              req_valid,
    output logic              req_write,
    output logic              req_mem,
    output logic [MEM_AW-1:0] req_addr,
    output logic [7:0]        req_wdata,
    input  logic              req_ready,
    input  logic [7:0]        rsp_rdata,
    input  logic              rsp_err
);
    localparam int NIB_IO  = IO_AW / 4;
    localparam int NIB_MEM = MEM_AW / 4;
    localparam int CW      = (NIB_MEM > 2) ? $clog2(NIB_MEM) : 1;

    typedef struct packed {
        lpc_st_e           st;
        logic [CW-1:0]     cnt;
        logic              is_mem;
        logic              is_wr;
        logic [MEM_AW-1:0] addr;
        logic [3:0]        wlo;
    } ctl_t;

    ctl_t r_q, r_d;

    logic [MEM_AW-1:0] addr_sh;
    logic [CW-1:0]     last_nib;
    logic              io_hit;
    logic              mem_hit;
    logic              win_hit;
    logic              iss;
    logic [MEM_AW-1:0] iss_addr;
    logic [7:0]        iss_wdata;
    logic              p_done;
    logic              p_err;
    logic [7:0]        p_rdata;

    // address shifts in most significant nibble first
    assign addr_sh  = {r_q.addr[MEM_AW-5:0], lad_i};
    assign last_nib = r_q.is_mem ? CW'(NIB_MEM - 1) : CW'(NIB_IO - 1);
    assign win_hit  = r_q.is_mem ? mem_hit : io_hit;

    lpc_win_match #(.AW(IO_AW)) u_io_win (
        .addr (addr_sh[IO_AW-1:0]),
        .lo   (io_lo),
        .hi   (io_hi),
        .hit  (io_hit)
    );

    lpc_win_match #(.AW(MEM_AW)) u_mem_win (
        .addr (addr_sh),
        .lo   (mem_lo),
        .hi   (mem_hi),
        .hit  (mem_hit)
    );

    always_comb begin
        r_d       = r_q;
        iss       = 1'b0;
        iss_addr  = r_q.addr;
        iss_wdata = {lad_i, r_q.wlo};

        unique case (r_q.st)
            ST_IDLE: begin
                r_d.st = ST_IDLE;
            end
            ST_TYPE: begin
                r_d.cnt  = '0;
                r_d.addr = '0;
                if (!lad_i[3]) begin
                    r_d.is_mem = lad_i[2];
                    r_d.is_wr  = lad_i[1];
                    r_d.st     = ST_ADDR;
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_ADDR: begin
                r_d.addr = addr_sh;
                r_d.cnt  = r_q.cnt + CW'(1);
                if (r_q.cnt == last_nib) begin
                    r_d.cnt = '0;
                    if (!win_hit) begin
                        r_d.st = ST_IDLE;
                    end else if (r_q.is_wr) begin
                        r_d.st = ST_WDAT;
                    end else begin
                        r_d.st   = ST_TAR_IN;
                        iss      = 1'b1;
                        iss_addr = addr_sh;
                    end
                end
            end
            ST_WDAT: begin
                if (r_q.cnt == '0) begin
                    r_d.wlo = lad_i;
                    r_d.cnt = CW'(1);
                end else begin
                    r_d.cnt = '0;
                    r_d.st  = ST_TAR_IN;
                    iss     = 1'b1;
                end
            end
            ST_TAR_IN: begin
                if (r_q.cnt == '0) begin
                    r_d.cnt = CW'(1);
                end else begin
                    r_d.cnt = '0;
                    r_d.st  = ST_SYNC;
                end
            end
            ST_SYNC: begin
                if (p_done) begin
                    r_d.cnt = '0;
                    r_d.st  = r_q.is_wr ? ST_TAR_OUT : ST_RDAT;
                end
            end
            ST_RDAT: begin
                if (r_q.cnt == '0) begin
                    r_d.cnt = CW'(1);
                end else begin
                    r_d.cnt = '0;
                    r_d.st  = ST_TAR_OUT;
                end
            end
            ST_TAR_OUT: begin
                if (r_q.cnt == '0) begin
                    r_d.cnt = CW'(1);
                end else begin
                    r_d.cnt = '0;
                    r_d.st  = ST_IDLE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase

        // frame strobe low: drop everything, maybe restart
        if (!frame_n) begin
            r_d.cnt = '0;
            r_d.st  = (lad_i == NIB_START) ? ST_TYPE : ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    lpc_req_port #(.AW(MEM_AW)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (!frame_n),
        .iss       (iss),
        .iss_write (r_q.is_wr),
        .iss_mem   (r_q.is_mem),
        .iss_addr  (iss_addr),
        .iss_wdata (iss_wdata),
        .req_ready (req_ready),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_mem   (req_mem),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .done      (p_done),
        .err       (p_err),
        .rdata     (p_rdata)
    );

    lpc_lad_drive u_drive (
        .st      (r_q.st),
        .second  (r_q.cnt[0]),
        .done    (p_done),
        .err     (p_err),
        .rdata   (p_rdata),
        .frame_n (frame_n),
        .lad_o   (lad_o),
        .lad_oe  (lad_oe)
    );
endmodule

// File: rtl/lpc_target_resp_chk.sv
module lpc_target_resp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_n,
    input logic [3:0] lad_i,
    input logic [3:0] lad_o,
    input logic       lad_oe,
    input logic       req_valid,
    input logic       req_ready
);
    // first nibble driven after the host turnaround is a SYNC code
    assert_first_drive_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lad_oe) |-> (lad_o == 4'b0000 || lad_o == 4'b0110 || lad_o == 4'b1010));

    // while the request is unfinished the only driven code is long wait
    assert_wait_while_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lad_oe) |-> (lad_o == 4'b0110));

    // a release without abort is preceded by the all-ones clock
    assert_release_after_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lad_oe) && frame_n && $past(frame_n)) |-> ($past(lad_o) == 4'b1111));

    // a non-start strobe leaves the bus undriven afterwards
    assert_abort_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && lad_i != 4'b0000) |=> !lad_oe);

    // an abort withdraws any request
    assert_abort_withdraw_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> !req_valid);

    // request is held until accepted
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && frame_n) |=> req_valid);

    // a request only ends by acceptance or abort
    assert_req_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(req_valid) && $past(frame_n)) |-> $past(req_ready));
endmodule

bind lpc_target_resp lpc_target_resp_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .lad_i     (lad_i),
    .lad_o     (lad_o),
    .lad_oe    (lad_oe),
    .req_valid (req_valid),
    .req_ready (req_ready)
);

// File: tb/test_lpc_target_resp.sv
module test_lpc_target_resp;

    logic        clk;
    logic        rst_n;
    logic        frame_n;
    logic [3:0]  lad_i;
    logic [3:0]  lad_o;
    logic        lad_oe;
    logic [15:0] io_lo, io_hi;
    logic [31:0] mem_lo, mem_hi;
    logic        req_valid, req_write, req_mem;
    logic [31:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ready;
    logic [7:0]  rsp_rdata;
    logic        rsp_err;

    lpc_target_resp i_lpc_target_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .lad_i     (lad_i),
        .lad_o     (lad_o),
        .lad_oe    (lad_oe),
        .io_lo     (io_lo),
        .io_hi     (io_hi),
        .mem_lo    (mem_lo),
        .mem_hi    (mem_hi),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_mem   (req_mem),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    typedef struct packed {
        logic        wr;
        logic        mem;
        logic [31:0] addr;
        logic [7:0]  wd;
    } exp_t;

    exp_t exp_q[$];

    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    // register-side reference state
    logic       obs_oe, obs_rv;
    logic [3:0] obs_lad;
    bit         rr_driven = 0;
    bit         done = 0;
    int         wait_cnt = 0;
    int         wait_cfg = 0;
    bit         cfg_err = 0;
    logic [7:0] cfg_rdata = 8'h00;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one bus clock: sample at negedge, model register side, drive host nibble
    task automatic step(input bit fr, input logic [3:0] nib);
        exp_t e;
        @(negedge clk);
        obs_oe  = lad_oe;
        obs_lad = lad_o;
        obs_rv  = req_valid;
        if (rr_driven) done = 1;
        rr_driven = 0;
        req_ready = 1'b0;
        if (!fr) begin
            wait_cnt = 0;
            done     = 0;
            exp_q.delete();
        end else if (obs_rv && !done) begin
            if (wait_cnt >= wait_cfg) begin
                req_ready = 1'b1;
                rr_driven = 1;
                if (exp_q.size() == 0) begin
                    chk(0, "R12 unexpected request", 32'(req_addr), 32'hFFFF_FFFF);
                end else begin
                    e = exp_q.pop_front();
                    chk(req_addr == e.addr, "R3 request address", req_addr, e.addr);
                    chk(req_write == e.wr && req_mem == e.mem, "R3 request type",
                        32'({req_mem, req_write}), 32'({e.mem, e.wr}));
                    if (e.wr) chk(req_wdata == e.wd, "R5 write byte", 32'(req_wdata), 32'(e.wd));
                end
            end else begin
                wait_cnt++;
            end
        end
        rsp_rdata = cfg_rdata;
        rsp_err   = cfg_err;
        frame_n   = fr;
        lad_i     = nib;
        if (!fr) begin
            #1;
            chk(lad_oe == 1'b0, "R11 enable drops with strobe", 32'(lad_oe), 32'd0);
        end
    endtask

    // returns 1 when the cycle was aborted during SYNC
    task automatic do_cycle(input bit skip_start, input bit mem, input bit wr, input bit tlsb,
                            input logic [31:0] addr, input logic [7:0] wd, input bit hit,
                            input int wcfg, input bit err, input logic [7:0] rd,
                            input int abort_after, input logic [3:0] abort_nib);
        int  n;
        int  waits;
        bit  fin;
        exp_t e;
        wait_cfg  = wcfg;
        cfg_err   = err;
        cfg_rdata = rd;
        if (!skip_start) step(1'b0, 4'b0000);
        if (hit) begin
            e.wr = wr; e.mem = mem; e.addr = addr; e.wd = wd;
            exp_q.push_back(e);
        end
        step(1'b1, {1'b0, mem, wr, tlsb});
        chk(obs_oe == 1'b0, "R1 no drive at start", 32'(obs_oe), 32'd0);
        n = mem ? 8 : 4;
        for (int i = n - 1; i >= 0; i--) begin
            step(1'b1, addr[4*i +: 4]);
            chk(obs_oe == 1'b0, "R3 host address phase undriven", 32'(obs_oe), 32'd0);
        end
        if (!hit) begin
            for (int k = 0; k < 6; k++) begin
                step(1'b1, 4'hF);
                chk(!obs_oe && !obs_rv, "R4 miss stays silent", 32'({obs_oe, obs_rv}), 32'd0);
            end
            return;
        end
        if (wr) begin
            step(1'b1, wd[3:0]);
            chk(obs_oe == 1'b0, "R5 data phase undriven", 32'(obs_oe), 32'd0);
            step(1'b1, wd[7:4]);
            chk(obs_oe == 1'b0, "R5 data phase undriven", 32'(obs_oe), 32'd0);
        end
        step(1'b1, 4'hF);
        chk(obs_oe == 1'b0, "R6 host turnaround 1", 32'(obs_oe), 32'd0);
        step(1'b1, 4'hF);
        chk(obs_oe == 1'b0, "R6 host turnaround 2", 32'(obs_oe), 32'd0);
        waits = 0;
        fin   = 0;
        for (int k = 0; k < 5000; k++) begin
            if (abort_after > 0 && waits == abort_after) begin
                step(1'b0, abort_nib);
                if (abort_nib != 4'b0000) begin
                    for (int j = 0; j < 3; j++) begin
                        step(1'b1, 4'hF);
                        chk(!obs_oe && !obs_rv, "R11 aborted cycle silent",
                            32'({obs_oe, obs_rv}), 32'd0);
                    end
                end
                return;
            end
            step(1'b1, 4'hF);
            chk(obs_oe == 1'b1, "R7 SYNC driven", 32'(obs_oe), 32'd1);
            if (obs_lad == 4'b0110) begin
                chk(!done, "R7 long wait only while pending", 32'(obs_lad), 32'h0);
                waits++;
            end else begin
                chk(done && obs_lad == (err ? 4'b1010 : 4'b0000), "R7 R8 SYNC completion code",
                    32'(obs_lad), err ? 32'hA : 32'h0);
                fin = 1;
                break;
            end
        end
        chk(fin, "R7 SYNC completed", 32'(fin), 32'd1);
        if (!wr) begin
            step(1'b1, 4'hF);
            chk(obs_oe && (err || obs_lad == rd[3:0]), "R9 R8 low data nibble",
                32'(obs_lad), 32'(rd[3:0]));
            step(1'b1, 4'hF);
            chk(obs_oe && (err || obs_lad == rd[7:4]), "R9 R8 high data nibble",
                32'(obs_lad), 32'(rd[7:4]));
        end
        step(1'b1, 4'hF);
        chk(obs_oe && obs_lad == 4'hF, "R10 ones before release", 32'({obs_oe, obs_lad}), 32'h1F);
        step(1'b1, 4'hF);
        chk(!obs_oe, "R10 bus released", 32'(obs_oe), 32'd0);
        step(1'b1, 4'hF);
        chk(!obs_oe && !obs_rv, "R10 idle after cycle", 32'({obs_oe, obs_rv}), 32'd0);
        chk(exp_q.size() == 0, "R12 one request per cycle", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic ignored_type(input logic [3:0] t);
        step(1'b0, 4'b0000);
        step(1'b1, t);
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 4'h0);
            chk(!obs_oe && !obs_rv, "R2 ignored cycle type", 32'({obs_oe, obs_rv}), 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog R7 actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        frame_n   = 1'b1;
        lad_i     = 4'hF;
        req_ready = 1'b0;
        rsp_rdata = 8'h00;
        rsp_err   = 1'b0;
        io_lo     = 16'h0300;
        io_hi     = 16'h031F;
        mem_lo    = 32'h8000_0000;
        mem_hi    = 32'h8000_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        step(1'b1, 4'h0);
        chk(!obs_oe && !obs_rv, "R1 reset state", 32'({obs_oe, obs_rv}), 32'd0);
        // R1: start nibble without strobe does nothing
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 4'h0);
            chk(!obs_oe && !obs_rv, "R1 no start without strobe", 32'({obs_oe, obs_rv}), 32'd0);
        end

        // R2 R3 R9: I/O read, immediate completion
        do_cycle(0, 0, 0, 0, 32'h0000_0305, 8'h00, 1, 0, 0, 8'hA5, 0, 4'h0);
        // R5 R7: I/O write with waits, type bit 0 set (R2 ignored bit)
        do_cycle(0, 0, 1, 1, 32'h0000_0310, 8'h3C, 1, 3, 0, 8'h00, 0, 4'h0);
        // R3: memory read, 8 nibbles
        do_cycle(0, 1, 0, 0, 32'h8000_1234, 8'h00, 1, 5, 0, 8'h96, 0, 4'h0);
        // R8: memory write with error
        do_cycle(0, 1, 1, 0, 32'h8000_FF00, 8'h71, 1, 2, 1, 8'h00, 0, 4'h0);
        // R8: I/O read with error still sends data nibbles
        do_cycle(0, 0, 0, 0, 32'h0000_0300, 8'h00, 1, 1, 1, 8'h5A, 0, 4'h0);
        // R4: window boundaries
        do_cycle(0, 0, 0, 0, 32'h0000_031F, 8'h00, 1, 0, 0, 8'hC3, 0, 4'h0);
        do_cycle(0, 0, 0, 0, 32'h0000_0320, 8'h00, 0, 0, 0, 8'h00, 0, 4'h0);
        do_cycle(0, 0, 1, 0, 32'h0000_02FF, 8'h11, 0, 0, 0, 8'h00, 0, 4'h0);
        do_cycle(0, 1, 0, 0, 32'h8001_0000, 8'h00, 0, 0, 0, 8'h00, 0, 4'h0);
        do_cycle(0, 1, 1, 0, 32'h8000_0000, 8'hE2, 1, 0, 0, 8'h00, 0, 4'h0);
        // R2: DMA and firmware-hub types
        ignored_type(4'b1000);
        ignored_type(4'b1101);
        // R7: long stall, no timeout
        do_cycle(0, 0, 0, 0, 32'h0000_0308, 8'h00, 1, 300, 0, 8'h4D, 0, 4'h0);
        // R11: abort with non-start nibble during long wait
        do_cycle(0, 0, 0, 0, 32'h0000_0301, 8'h00, 1, 20, 0, 8'h00, 3, 4'hF);
        // R11: abort with start nibble, then a fresh write cycle
        do_cycle(0, 1, 0, 0, 32'h8000_0040, 8'h00, 1, 20, 0, 8'h00, 4, 4'h0);
        do_cycle(1, 0, 1, 0, 32'h0000_0302, 8'h9B, 1, 1, 0, 8'h00, 0, 4'h0);
        // R11: strobe during address phase drops the cycle
        step(1'b0, 4'b0000);
        step(1'b1, 4'b0000);
        step(1'b1, 4'h0);
        step(1'b1, 4'h3);
        step(1'b0, 4'hF);
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 4'h0);
            chk(!obs_oe && !obs_rv, "R11 address-phase abort", 32'({obs_oe, obs_rv}), 32'd0);
        end
        // R1: normal cycle still works afterwards
        do_cycle(0, 0, 0, 0, 32'h0000_0304, 8'h00, 1, 2, 0, 8'h68, 0, 4'h0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule